// File: doc/BRIEF.md
# Per-Partition Scan and Reduce Accumulator

This block sits behind a tensor-scalar datapath. It keeps one running 32-bit accumulator per partition lane and folds a stream of elements into it. Elements arrive as vectors on a valid/ready stream, and the last element of each vector is marked. In reduce mode the block emits one result per vector, which is the final accumulator value. In cumulative mode and in scan mode it emits the inclusive running prefix for every element.

How the accumulator starts each vector is set by a small command code. The accumulator can be held idle, cleared, cleared and then accumulated, continued from its value after the previous vector, or loaded from a seed immediate. Mode, command, seed and direction are sampled with the first element of a vector and held for the rest of it. A separate request/acknowledge drain port returns the final accumulator value when no vector is open. A flag reports an illegal mode, and a second flag reports a non-zero seed given with any command other than load.

Both streams use valid/ready. An element moves when valid and ready are both high at a rising edge. The input is ready whenever the output register is empty or is being emptied in the same cycle. While out_valid is high and out_ready is low, the output holds its data and last flag unchanged. A source must hold in_valid and its data until the element is taken.

Top module: `sacc_top`

## Requirements
- R1: With mode_sel = 0 (reduce), the block emits exactly one output per vector, on the element marked in_last. That output has out_last = 1 and carries the final accumulator value. instr_code reads 0x9A.
- R2: With mode_sel = 1 (cumulative) or mode_sel = 2 (scan), the block emits one output per element, in arrival order. Each output is the inclusive running prefix, out_last copies in_last, and instr_code reads 0xE6.
- R3: With mode_sel = 3, the vector's elements are consumed and produce no output, and the accumulator is left unchanged. mode_err reads 1 and instr_code reads 0x00 until the next vector starts.
- R4: acc_cmd = 0 (idle) leaves the accumulator neither cleared nor updated, so every output equals the held value. acc_cmd = 1 (zero) clears the accumulator and adds nothing, so every output is 0.
- R5: acc_cmd = 3 starts the vector from 0 and adds each element. acc_cmd = 2 starts from the accumulator value left by the previous vector and adds each element. acc_cmd = 4 starts from seed_imm and adds each element.
- R6: acc_cmd values 5, 6 and 7 behave as idle.
- R7: seed_err reads 1 for a vector whose seed_imm is non-zero while acc_cmd is not 4. In that case the seed has no effect on the results.
- R8: scan_rev = 1 selects reverse traversal. The upstream source presents the elements last-to-first, the arithmetic is the same as forward, and outputs follow arrival order. vec_rev reports the latched direction of the current vector.
- R9: Accumulation is 32-bit addition that wraps modulo 2^32.
- R10: in_ready equals !out_valid || out_ready. While out_valid = 1 and out_ready = 0, out_data and out_last hold stable.
- R11: While drain_req is high and no vector is open, drain_ack pulses for one cycle, one cycle later, with drain_data equal to the accumulator. A request made while a vector is open waits for the vector's last element.
- R12: After reset, out_valid, drain_ack, mode_err, seed_err and vec_rev are 0, instr_code is 0x00, and the accumulator is 0.
- R13: Mode, command, seed and direction are sampled with a vector's first element. Changes to them during the vector have no effect until the next vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 reduce, 1 cumulative, 2 scan, 3 illegal |
| acc_cmd | input | 3 | Start command: 0 idle, 1 zero, 2 add-accumulate, 3 zero-accumulate, 4 load-accumulate |
| seed_imm | input | 32 | Seed used by load-accumulate |
| scan_rev | input | 1 | Traversal direction: 0 forward, 1 reverse |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted when high with in_valid |
| in_data | input | 32 | Input element |
| in_last | input | 1 | Marks the last element of a vector |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 32 | Prefix or reduced value |
| out_last | output | 1 | Marks the last output of a vector |
| drain_req | input | 1 | Request to read the accumulator |
| drain_ack | output | 1 | One-cycle acknowledge, drain_data valid |
| drain_data | output | 32 | Accumulator value returned by the drain |
| mode_err | output | 1 | Current vector has an illegal mode |
| seed_err | output | 1 | Non-zero seed given without load-accumulate |
| instr_code | output | 8 | Operation code of current vector: 0x9A, 0xE6 or 0x00 |
| vec_rev | output | 1 | Direction latched for current vector |

## Verification
The hardest situation to reach from the ports is a drain request that arrives while a vector is open and the output is also back-pressured. The acknowledge must wait for the last element, and the accumulator it returns must include that element. The bench asserts drain_req just after a vector's first element is accepted, throttles out_ready, and inserts valid gaps. A second hard case is a configuration change in the middle of a vector. The bench changes every configuration input after the first element is taken and expects results from the originally sampled setup. A behavioural model tracks each of these cycles and is compared on every clock.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  localparam int MODE_W = 2;
  localparam int CMD_W  = 3;
  localparam int CODE_W = 8;

  localparam logic [MODE_W-1:0] MODE_REDUCE = 2'd0;
  localparam logic [MODE_W-1:0] MODE_CUMUL  = 2'd1;
  localparam logic [MODE_W-1:0] MODE_SCAN   = 2'd2;

  localparam logic [CMD_W-1:0] CMD_IDLE     = 3'd0;
  localparam logic [CMD_W-1:0] CMD_ZERO     = 3'd1;
  localparam logic [CMD_W-1:0] CMD_ADD_ACC  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_ZERO_ACC = 3'd3;
  localparam logic [CMD_W-1:0] CMD_LOAD_ACC = 3'd4;

  localparam logic [CODE_W-1:0] CODE_REDUCE = 8'h9A;
  localparam logic [CODE_W-1:0] CODE_PREFIX = 8'hE6;
  localparam logic [CODE_W-1:0] CODE_NONE   = 8'h00;

  typedef enum logic [1:0] {
    START_HOLD,
    START_CLEAR,
    START_SEED
  } start_src_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m == MODE_REDUCE) || (m == MODE_CUMUL) || (m == MODE_SCAN);
  endfunction

  function automatic start_src_e start_src(input logic [CMD_W-1:0] c);
    case (c)
      CMD_ZERO, CMD_ZERO_ACC: return START_CLEAR;
      CMD_LOAD_ACC:           return START_SEED;
      default:                return START_HOLD;
    endcase
  endfunction

  function automatic logic cmd_adds(input logic [CMD_W-1:0] c);
    return (c == CMD_ADD_ACC) || (c == CMD_ZERO_ACC) || (c == CMD_LOAD_ACC);
  endfunction

  function automatic logic [CODE_W-1:0] op_code(input logic [MODE_W-1:0] m);
    case (m)
      MODE_REDUCE:           return CODE_REDUCE;
      MODE_CUMUL, MODE_SCAN: return CODE_PREFIX;
      default:               return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sacc_cfg.sv
module sacc_cfg
  import sacc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              last,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              rev_in,
  input  logic [DATA_W-1:0] seed_in,
  output logic [MODE_W-1:0] mode_act,
  output logic [CMD_W-1:0]  cmd_act,
  output logic              first,
  output logic              in_vec,
  output logic              mode_err,
  output logic              seed_err,
  output logic [CODE_W-1:0] code,
  output logic              vec_rev
);
  logic [MODE_W-1:0] mode_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              start;

  assign first    = !in_vec;
  assign start    = fire && first;
  assign mode_act = first ? mode_in : mode_q;
  assign cmd_act  = first ? cmd_in  : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_vec   <= 1'b0;
      mode_q   <= MODE_REDUCE;
      cmd_q    <= CMD_IDLE;
      mode_err <= 1'b0;
      seed_err <= 1'b0;
      code     <= CODE_NONE;
      vec_rev  <= 1'b0;
    end else begin
      if (fire) in_vec <= !last;
      if (start) begin
        mode_q   <= mode_in;
        cmd_q    <= cmd_in;
        mode_err <= !mode_legal(mode_in);
        seed_err <= (seed_in != '0) && (cmd_in != CMD_LOAD_ACC);
        code     <= op_code(mode_in);
        vec_rev  <= rev_in;
      end
    end
  end

  // R3
  mode_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (code == CODE_NONE));

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmd_in == CMD_LOAD_ACC) |=> !seed_err);

  // R13
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vec && !(fire && last)) |=> ($stable(mode_act) && $stable(cmd_act) && $stable(vec_rev)));
endmodule

// File: rtl/sacc_accum.sv
module sacc_accum
  import sacc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              first,
  input  logic              last,
  input  logic [MODE_W-1:0] mode_act,
  input  logic [CMD_W-1:0]  cmd_act,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] val,
  output logic              produce
);
  logic [DATA_W-1:0] base;
  logic              legal;

  always_comb begin
    base = acc;
    if (first) begin
      case (start_src(cmd_act))
        START_CLEAR: base = '0;
        START_SEED:  base = seed;
        default:     base = acc;
      endcase
    end
    val = cmd_adds(cmd_act) ? (base + din) : base;
  end

  assign legal   = mode_legal(mode_act);
  assign produce = fire && legal && ((mode_act != MODE_REDUCE) || last);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (fire && legal) acc <= val;
  end

  // R3
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !legal) |=> $stable(acc));

  // R4
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal && cmd_act == CMD_ZERO) |=> (acc == '0));

  // R4
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_act == CMD_IDLE) |=> $stable(acc));

  // R1
  reduce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_act == MODE_REDUCE && !last) |-> !produce);
endmodule

// File: rtl/sacc_out.sv
module sacc_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              produce,
  input  logic [DATA_W-1:0] val,
  input  logic              last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              in_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (produce) begin
      out_valid <= 1'b1;
      out_data  <= val;
      out_last  <= last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !produce);
endmodule

// File: rtl/sacc_drain.sv
module sacc_drain #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drain_req,
  input  logic              busy,
  input  logic [DATA_W-1:0] acc,
  output logic              drain_ack,
  output logic [DATA_W-1:0] drain_data
);
  logic grant;

  assign grant = drain_req && !drain_ack && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_ack  <= 1'b0;
      drain_data <= '0;
    end else begin
      drain_ack <= grant;
      if (grant) drain_data <= acc;
    end
  end

  // R11
  drain_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ack |=> !drain_ack);

  // R11
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ack |-> ($past(drain_req) && !$past(busy)));
endmodule

// File: rtl/sacc_top.sv
module sacc_top
  import sacc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_sel,
  input  logic [2:0]             acc_cmd,
  input  logic [DATA_W-1:0]      seed_imm,
  input  logic                   scan_rev,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data,
  output logic                   out_last,
  input  logic                   drain_req,
  output logic                   drain_ack,
  output logic [DATA_W-1:0]      drain_data,
  output logic                   mode_err,
  output logic                   seed_err,
  output logic [7:0]             instr_code,
  output logic                   vec_rev
);
  logic              fire;
  logic              first;
  logic              in_vec;
  logic              produce;
  logic [MODE_W-1:0] mode_act;
  logic [CMD_W-1:0]  cmd_act;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] val;

  assign fire = in_valid && in_ready;

  sacc_cfg #(.DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(in_last),
    .mode_in(mode_sel), .cmd_in(acc_cmd), .rev_in(scan_rev), .seed_in(seed_imm),
    .mode_act(mode_act), .cmd_act(cmd_act), .first(first), .in_vec(in_vec),
    .mode_err(mode_err), .seed_err(seed_err), .code(instr_code), .vec_rev(vec_rev)
  );

  sacc_accum #(.DATA_W(DATA_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(first), .last(in_last),
    .mode_act(mode_act), .cmd_act(cmd_act), .seed(seed_imm), .din(in_data),
    .acc(acc), .val(val), .produce(produce)
  );

  sacc_out #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .produce(produce), .val(val), .last(in_last),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .in_ready(in_ready)
  );

  sacc_drain #(.DATA_W(DATA_W)) drain_i (
    .clk(clk), .rst_n(rst_n), .drain_req(drain_req), .busy(in_vec), .acc(acc),
    .drain_ack(drain_ack), .drain_data(drain_data)
  );

  // R2
  prefix_per_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode_act == MODE_CUMUL || mode_act == MODE_SCAN)) |=> (out_valid && out_last == $past(in_last)));

  // R1
  reduce_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_act == MODE_REDUCE && in_last) |=> (out_valid && out_last && out_data == acc));
endmodule

// File: tb/sacc_top_tb_top.sv
`timescale 1ns/1ps
module sacc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic [2:0]  acc_cmd = '0;
  logic [31:0] seed_imm = '0;
  logic        scan_rev = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_last;
  logic        drain_req = 1'b0;
  logic        drain_ack;
  logic [31:0] drain_data;
  logic        mode_err;
  logic        seed_err;
  logic [7:0]  instr_code;
  logic        vec_rev;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R12";

  always #2.5 clk = ~clk;

  sacc_top dut_i (.*);

  // behavioural reference state
  logic [31:0] m_acc = 0, m_od = 0, m_dd = 0;
  logic        m_ov = 0, m_ol = 0, m_inv = 0, m_dack = 0, m_merr = 0, m_serr = 0, m_rev = 0;
  logic [7:0]  m_code = 0;
  logic [1:0]  l_mode = 0;
  logic [2:0]  l_cmd = 0;
  logic        m_fire;
  logic [31:0] got[$];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic first; logic [1:0] md; logic [2:0] cm; logic [31:0] b, v;
    logic rdy;
    logic [31:0] acc_now;
    rdy = !m_ov || out_ready;
    m_fire = in_valid && rdy;
    acc_now = m_acc;
    if (drain_req && !m_dack && !m_inv) begin m_dack = 1; m_dd = acc_now; end
    else m_dack = 0;
    if (m_ov && out_ready) m_ov = 0;
    if (m_fire) begin
      first = !m_inv;
      md = first ? mode_sel : l_mode;
      cm = first ? acc_cmd : l_cmd;
      b = acc_now;
      if (first && (cm == 1 || cm == 3)) b = 0;
      if (first && cm == 4) b = seed_imm;
      v = (cm == 2 || cm == 3 || cm == 4) ? b + in_data : b;
      if (md != 3) begin
        m_acc = v;
        if (md != 0 || in_last) begin m_ov = 1; m_od = v; m_ol = in_last; end
      end
      if (first) begin
        l_mode = mode_sel; l_cmd = acc_cmd;
        m_merr = (mode_sel == 3);
        m_serr = (seed_imm != 0) && (acc_cmd != 4);
        m_code = (mode_sel == 0) ? 8'h9A : (mode_sel == 3) ? 8'h00 : 8'hE6;
        m_rev  = scan_rev;
      end
      m_inv = !in_last;
    end
  endtask

  task automatic tick();
    #1;
    chk("in_ready", {31'd0, in_ready}, {31'd0, (!m_ov || out_ready)});
    if (out_valid && out_ready) got.push_back(out_data);
    model_step();
    @(posedge clk); @(negedge clk);
    chk("out_valid", {31'd0, out_valid}, {31'd0, m_ov});
    if (m_ov) begin
      chk("out_data", out_data, m_od);
      chk("out_last", {31'd0, out_last}, {31'd0, m_ol});
    end
    chk("drain_ack", {31'd0, drain_ack}, {31'd0, m_dack});
    if (m_dack) chk("drain_data", drain_data, m_dd);
    chk("mode_err", {31'd0, mode_err}, {31'd0, m_merr});
    chk("seed_err", {31'd0, seed_err}, {31'd0, m_serr});
    chk("instr_code", {24'd0, instr_code}, {24'd0, m_code});
    chk("vec_rev", {31'd0, vec_rev}, {31'd0, m_rev});
    if (drain_ack) drain_req = 0;
  endtask

  // runs one vector; bp throttles out_ready, gaps inserts idle cycles,
  // scramble changes the configuration after the first element, dmid requests a drain mid-vector
  task automatic run_vec(input logic [31:0] d[$], input bit bp, input bit gaps,
                         input bit scramble, input bit dmid);
    int idx = 0; int cyc = 0; bit hold = 0;
    got.delete();
    while (idx < d.size() || m_ov) begin
      out_ready = bp ? (cyc % 4 < 2) : 1'b1;
      if (!hold) in_valid = (idx < d.size()) && !(gaps && (cyc % 3 == 1));
      in_data = (idx < d.size()) ? d[idx] : 32'd0;
      in_last = (idx == d.size() - 1);
      tick();
      hold = in_valid && !m_fire;
      if (m_fire) begin
        idx++;
        if (idx == 1 && scramble) begin
          mode_sel = 2'd3; acc_cmd = 3'd1; seed_imm = 32'd5; scan_rev = ~scan_rev;
        end
        if (idx == 1 && dmid) drain_req = 1;
      end
      if (idx >= d.size()) in_valid = 0;
      cyc++;
    end
    out_ready = 1; in_valid = 0; in_last = 0;
    if (got.size() == 0 || 1) begin end
    tick();
  endtask

  task automatic expect_got(input logic [31:0] e[$]);
    chk("output count", got.size(), e.size());
    foreach (e[i]) if (i < got.size()) chk("output value", got[i], e[i]);
  endtask

  task automatic do_drain(input logic [31:0] exp);
    bit seen = 0;
    drain_req = 1;
    for (int i = 0; i < 10 && !seen; i++) begin
      tick();
      if (drain_ack) begin seen = 1; chk("drain result", drain_data, exp); end
    end
    chk("drain acknowledged", {31'd0, seen}, 32'd1);
    drain_req = 0;
    tick();
  endtask

  task automatic setcfg(input logic [1:0] m, input logic [2:0] c, input logic [31:0] s, input logic r);
    mode_sel = m; acc_cmd = c; seed_imm = s; scan_rev = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] e[$];
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R12";
    chk("out_valid after reset", {31'd0, out_valid}, 0);
    chk("drain_ack after reset", {31'd0, drain_ack}, 0);
    chk("instr_code after reset", {24'd0, instr_code}, 0);
    chk("flags after reset", {29'd0, mode_err, seed_err, vec_rev}, 0);
    do_drain(32'd0);

    tag = "R2"; setcfg(2'd1, 3'd3, 0, 0);
    run_vec('{32'd1, 32'd2, 32'd3, 32'd4}, 0, 0, 0, 0);
    e = '{32'd1, 32'd3, 32'd6, 32'd10}; expect_got(e);
    chk("R2 instr_code", {24'd0, instr_code}, 32'hE6);

    tag = "R5"; setcfg(2'd1, 3'd2, 0, 0);
    run_vec('{32'd5, 32'd5}, 0, 1, 0, 0);
    e = '{32'd15, 32'd20}; expect_got(e);
    tag = "R11"; do_drain(32'd20);

    tag = "R1"; setcfg(2'd0, 3'd4, 32'd100, 0);
    run_vec('{32'd1, 32'd2, 32'd3}, 1, 1, 0, 0);
    e = '{32'd106}; expect_got(e);
    chk("R1 instr_code", {24'd0, instr_code}, 32'h9A);

    tag = "R8"; setcfg(2'd2, 3'd3, 0, 1);
    run_vec('{32'd30, 32'd20, 32'd10}, 1, 0, 0, 0);
    e = '{32'd30, 32'd50, 32'd60}; expect_got(e);
    chk("R8 vec_rev", {31'd0, vec_rev}, 32'd1);

    tag = "R10"; setcfg(2'd1, 3'd3, 0, 0);
    run_vec('{32'd2, 32'd4, 32'd6, 32'd8, 32'd10}, 1, 1, 0, 0);
    e = '{32'd2, 32'd6, 32'd12, 32'd20, 32'd30}; expect_got(e);

    tag = "R4"; setcfg(2'd1, 3'd0, 0, 0);
    run_vec('{32'd7, 32'd8}, 0, 0, 0, 0);
    e = '{32'd30, 32'd30}; expect_got(e);
    setcfg(2'd1, 3'd1, 0, 0);
    run_vec('{32'd7, 32'd8}, 0, 0, 0, 0);
    e = '{32'd0, 32'd0}; expect_got(e);

    tag = "R6"; setcfg(2'd0, 3'd2, 0, 0);
    run_vec('{32'd9}, 0, 0, 0, 0);
    setcfg(2'd1, 3'd5, 0, 0);
    run_vec('{32'd4, 32'd4}, 0, 0, 0, 0);
    e = '{32'd9, 32'd9}; expect_got(e);

    tag = "R3"; setcfg(2'd3, 3'd3, 0, 0);
    run_vec('{32'd1, 32'd2}, 0, 0, 0, 0);
    chk("R3 no outputs", got.size(), 0);
    chk("R3 mode_err", {31'd0, mode_err}, 32'd1);
    chk("R3 instr_code", {24'd0, instr_code}, 32'h00);
    do_drain(32'd9);

    tag = "R7"; setcfg(2'd1, 3'd3, 32'd77, 0);
    run_vec('{32'd2}, 0, 0, 0, 0);
    e = '{32'd2}; expect_got(e);
    chk("R7 seed_err", {31'd0, seed_err}, 32'd1);

    tag = "R9"; setcfg(2'd0, 3'd4, 32'hFFFF_FFFE, 0);
    run_vec('{32'd1, 32'd2}, 0, 0, 0, 0);
    e = '{32'd1}; expect_got(e);
    chk("R9 seed_err clear", {31'd0, seed_err}, 32'd0);

    tag = "R13"; setcfg(2'd1, 3'd3, 0, 0);
    run_vec('{32'd1, 32'd1, 32'd1}, 0, 1, 1, 0);
    e = '{32'd1, 32'd2, 32'd3}; expect_got(e);
    chk("R13 instr_code", {24'd0, instr_code}, 32'hE6);

    tag = "R11"; setcfg(2'd0, 3'd2, 0, 0);
    run_vec('{32'd4, 32'd4}, 1, 1, 0, 1);
    e = '{32'd11}; expect_got(e);
    for (int i = 0; i < 4 && drain_req; i++) tick();
    chk("R11 deferred drain served", {31'd0, drain_req}, 32'd0);
    chk("R11 deferred drain value", m_dd, 32'd11);
    chk("R11 drain_data", drain_data, 32'd11);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule